// File: doc/BRIEF.md
# Counter-Sequenced Serial Sample Reader

This block reads a serial successive-approximation converter that returns one 8-bit result per conversion, most significant bit first. A single free-running counter on the system clock sequences the whole transaction. There is no state machine. The counter's upper bits split each 256-count frame into sixteen slots of sixteen counts. One counter tap is the converter's serial clock. The AND of the two top bits is the converter's active-low select, which is high only in the last quarter of the frame.

Slot 0 is a setup slot and carries no data. In slots 1 to 8, the data line is sampled once per slot, on the system edge where the serial clock rises. That is half a serial-clock period after the converter changes the bit on the falling edge. Each sample is shifted into a register that moves toward its MSB and takes the new bit at bit 0. When the slot number first equals 10, a one-cycle strobe copies the collected byte into a holding register. That register drives a display or any later consumer.

All logic is synchronous to one clock. The shift and the capture are clock enables decoded from the counter.

Top module: `sar_serial_reader`

## Requirements
- R1: A synchronous reset clears the counter, the shift register, the holding register and the capture edge detector. While reset is sampled high and on the cycle after, `sample` is 0, `adc_sclk` is 0 and `adc_cs_n` is 0.
- R2: `adc_sclk` equals bit 3 of the counter, which advances by one on every clock after reset. The serial clock is therefore low for counts 16k..16k+7 and high for counts 16k+8..16k+15, a period of 16 system clocks.
- R3: `adc_cs_n` is 1 exactly when the counter is in 192..255 (both top bits set) and is 0 for counts 0..191.
- R4: The slot number is counter bits 7..4. In slots 1..8, `adc_dout` is sampled on the edge that moves the count from 16k+7 to 16k+8. Slot 1 supplies result bit 7 and slot 8 supplies bit 0, so the byte is received MSB first.
- R5: The value of `adc_dout` in slot 0, in slots 9..15, and on any cycle other than the sampling edge has no effect on `sample`.
- R6: `sample` takes the collected byte on the edge that ends count 160 (the first count of slot 10). The new value is visible from count 161, once per frame.
- R7: Between captures `sample` holds its value on every cycle, including through the remaining 15 counts of slot 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_dout | input | 1 | Serial result bit from the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_cs_n | output | 1 | Converter select, active low |
| sample | output | 8 | Last captured result |

## Verification
If the counter is corrupted, it shows within one system clock on `adc_sclk` or `adc_cs_n`, because both are taps of that counter and are compared on every cycle. A wrong sampling phase, wrong bit order or open data window does not show until count 161 of the same frame. At that point it appears as a wrong `sample`, because noise is driven on the data line outside the valid window. A capture strobe decoded at the wrong slot changes `sample` before count 161, so the per-cycle comparison of `sample` against the previous byte catches it within that frame.

// File: rtl/sar_rd_pkg.sv
`timescale 1ns/1ps
package sar_rd_pkg;

   // control enables decoded from the frame counter
   typedef struct packed {
      logic sclk;
      logic cs_n;
      logic shift_en;
      logic capture;
   } sar_rd_ctl_t;

   function automatic int slot_width(input int cnt_w, input int sclk_bit);
      return cnt_w - sclk_bit - 1;
   endfunction

endpackage

// File: rtl/sar_rd_timebase.sv
`timescale 1ns/1ps
module sar_rd_timebase #(
   parameter int CNT_W      = 8,
   parameter int SCLK_BIT   = 3,
   parameter int DATA_W     = 8,
   parameter int FIRST_SLOT = 1,
   parameter int CAP_SLOT   = 10,
   parameter bit CAP_EDGE   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   output sar_rd_pkg::sar_rd_ctl_t ctl_o
);
   localparam int SLOT_W    = sar_rd_pkg::slot_width(CNT_W, SCLK_BIT);
   localparam int NSLOT     = 1 << SLOT_W;
   localparam int LAST_SLOT = FIRST_SLOT + DATA_W - 1;
   localparam int SEL_SLOT  = (NSLOT * 3) / 4;
   localparam logic [SCLK_BIT:0] SAMPLE_PH = {1'b0, {SCLK_BIT{1'b1}}};

   generate
      if (SCLK_BIT < 1) begin : g_bad_tap
         $error("SCLK_BIT must be at least 1");
      end
      if (SLOT_W < 2) begin : g_bad_slotw
         $error("counter too narrow for a slot field of two bits");
      end
      if (FIRST_SLOT < 1) begin : g_bad_setup
         $error("slot 0 is reserved for converter setup");
      end
      if (LAST_SLOT >= CAP_SLOT) begin : g_bad_cap_early
         $error("capture slot must follow the last data slot");
      end
      if (CAP_SLOT >= SEL_SLOT) begin : g_bad_cap_late
         $error("capture slot must lie inside the selected window");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [SLOT_W-1:0] slot;
   logic [SCLK_BIT:0] phase;
   logic              in_window;
   logic              cap_hit;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   assign slot      = cnt_q[CNT_W-1 -: SLOT_W];
   assign phase     = cnt_q[SCLK_BIT:0];
   assign in_window = (slot >= SLOT_W'(FIRST_SLOT)) && (slot <= SLOT_W'(LAST_SLOT));

   assign ctl_o.sclk     = cnt_q[SCLK_BIT];
   assign ctl_o.cs_n     = &cnt_q[CNT_W-1 -: 2];
   assign ctl_o.shift_en = in_window && (phase == SAMPLE_PH);
   assign ctl_o.capture  = cap_hit;

   generate
      if (CAP_EDGE) begin : g_cap_edge
         logic match_now;
         logic match_q;
         assign match_now = (slot == SLOT_W'(CAP_SLOT));
         always_ff @(posedge clk) begin
            if (rst) match_q <= 1'b0;
            else     match_q <= match_now;
         end
         assign cap_hit = match_now && !match_q;
      end else begin : g_cap_exact
         assign cap_hit = (cnt_q == {SLOT_W'(CAP_SLOT), {(SCLK_BIT+1){1'b0}}});
      end
   endgenerate

   // counter moves by exactly one per clock
   p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> cnt_q == $past(cnt_q) + 1'b1);

   // serial clock only toggles at a half-period boundary
   p_sclk_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[SCLK_BIT-1:0] != {SCLK_BIT{1'b1}}) |=> $stable(ctl_o.sclk));

   // select rises only entering the last quarter
   p_sel_rise_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(ctl_o.cs_n) |-> slot == SLOT_W'(SEL_SLOT));

   // sampling happens with select low, on the low sclk phase
   p_shift_gate_r5: assert property (@(posedge clk) disable iff (rst)
      ctl_o.shift_en |-> (!ctl_o.cs_n && !ctl_o.sclk));

   // capture strobe lasts one cycle
   p_cap_single_r6: assert property (@(posedge clk) disable iff (rst)
      ctl_o.capture |=> !ctl_o.capture);

   p_cap_no_shift_r6: assert property (@(posedge clk) disable iff (rst)
      ctl_o.capture |-> !ctl_o.shift_en);
endmodule

// File: rtl/sar_rd_shifter.sv
`timescale 1ns/1ps
module sar_rd_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              din,
   output logic [DATA_W-1:0] q
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] nxt;

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_bit
         if (gi == 0) begin : g_lsb
            assign nxt[gi] = din;
         end else begin : g_up
            assign nxt[gi] = q[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)           q <= '0;
      else if (shift_en) q <= nxt;
   end

   // no movement without an enable
   p_shift_idle_r5: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(q));
endmodule

// File: rtl/sar_rd_hold.sv
`timescale 1ns/1ps
module sar_rd_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= din;
   end

   p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (q == '0));
endmodule

// File: rtl/sar_serial_reader.sv
`timescale 1ns/1ps
module sar_serial_reader #(
   parameter int CNT_W      = 8,
   parameter int SCLK_BIT   = 3,
   parameter int DATA_W     = 8,
   parameter int FIRST_SLOT = 1,
   parameter int CAP_SLOT   = 10,
   parameter bit CAP_EDGE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adc_dout,
   output logic              adc_sclk,
   output logic              adc_cs_n,
   output logic [DATA_W-1:0] sample
);
   sar_rd_pkg::sar_rd_ctl_t ctl;
   logic [DATA_W-1:0]       shreg;

   sar_rd_timebase #(
      .CNT_W(CNT_W), .SCLK_BIT(SCLK_BIT), .DATA_W(DATA_W),
      .FIRST_SLOT(FIRST_SLOT), .CAP_SLOT(CAP_SLOT), .CAP_EDGE(CAP_EDGE)
   ) u_tb (
      .clk(clk), .rst(rst), .ctl_o(ctl)
   );

   sar_rd_shifter #(.DATA_W(DATA_W)) u_sh (
      .clk(clk), .rst(rst), .shift_en(ctl.shift_en), .din(adc_dout), .q(shreg)
   );

   sar_rd_hold #(.DATA_W(DATA_W)) u_hd (
      .clk(clk), .rst(rst), .load(ctl.capture), .din(shreg), .q(sample)
   );

   assign adc_sclk = ctl.sclk;
   assign adc_cs_n = ctl.cs_n;

   p_rst_outputs_r1: assert property (@(posedge clk)
      rst |=> (!adc_sclk && !adc_cs_n));
endmodule

// File: tb/test_sar_serial_reader.sv
`timescale 1ns/1ps
module test_sar_serial_reader;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       adc_dout = 1'b0;
   logic       adc_sclk;
   logic       adc_cs_n;
   logic [7:0] sample;

   int unsigned n_total = 0;
   int unsigned n_fail  = 0;
   bit          done    = 1'b0;

   always #2 clk = ~clk;

   sar_serial_reader i_sar_serial_reader (
      .clk(clk), .rst(rst), .adc_dout(adc_dout),
      .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n), .sample(sample)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit exp_sclk(input logic [7:0] c);
      return c[3];
   endfunction

   function automatic bit exp_sel(input logic [7:0] c);
      return c[7] & c[6];
   endfunction

   function automatic bit slot_bit(input logic [7:0] b, input int s);
      return b[8 - s];
   endfunction

   initial begin
      logic [7:0] n;
      logic [7:0] cur_byte;
      logic [7:0] exp_hold;
      logic [7:0] directed [6];
      bit         rs;
      int         fi;
      int unsigned sd;
      sd = $urandom(32'd20517);
      directed[0] = 8'h00; directed[1] = 8'hFF; directed[2] = 8'h80;
      directed[3] = 8'h01; directed[4] = 8'hA5; directed[5] = 8'h5A;
      n = 8'd0; cur_byte = 8'd0; exp_hold = 8'd0; fi = 0;
      for (int it = 0; it < 12000; it++) begin
         @(posedge clk);
         rs = rst;
         #1;
         n = rs ? 8'd0 : n + 8'd1;
         if (rs) begin
            exp_hold = 8'd0;
            chk(sample == 8'd0, "R1 sample cleared", sample, 0);
            chk(adc_sclk == 1'b0, "R1 sclk low", adc_sclk, 0);
            chk(adc_cs_n == 1'b0, "R1 select low", adc_cs_n, 0);
         end else begin
            if (n == 8'd1) begin
               cur_byte = (fi < 6) ? directed[fi] : 8'($urandom());
               fi++;
            end
            if (n == 8'd161) exp_hold = cur_byte;  // R6 capture visible at 161
            chk(adc_sclk == exp_sclk(n), "R2 serial clock tap", adc_sclk, exp_sclk(n));
            chk(adc_cs_n == exp_sel(n), "R3 select window", adc_cs_n, exp_sel(n));
            if (n == 8'd161)
               chk(sample == exp_hold, "R4 R5 R6 captured byte", sample, exp_hold);
            else
               chk(sample == exp_hold, "R7 sample held", sample, exp_hold);
         end
         // converter stub: valid bits in slots 1..8, noise elsewhere (R5)
         begin
            int s;
            s = int'(n[7:4]);
            if (!rs && s >= 1 && s <= 8) adc_dout = slot_bit(cur_byte, s);
            else                         adc_dout = 1'($urandom());
         end
         // reset schedule: initial and one mid-frame pulse
         rst = (it < 3) || (it >= 6100 && it < 6102);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end
endmodule